// File: doc/BRIEF.md
# PHY Control-Port Handshake Sequencer

This block sits between a simple command requester and the internal control port of a serial-link PHY. The requester issues one of three operations on a valid/ready interface: latch a register address, write a value, or read a value. The block turns each operation into a series of four-phase strobe/acknowledge handshakes on the PHY's port, then reports completion or timeout with a one-cycle pulse. Read data is returned on a held output.

The PHY port has a 16-bit data-in bus, four strobes, one acknowledge line and a 16-bit data-out bus. The strobes are address capture, data capture, write commit and read. The acknowledge line is polled a bounded number of times, with a fixed gap between polls. The gap is a parameter in clock cycles, so the same logic can wait through microsecond delays in silicon and short ones in simulation. A write whose value has bit 0 set asks the PHY to reset itself. Such a PHY cannot answer, so the write strobe is raised and the operation ends without waiting for acknowledge.

Top module: `phy_port_sequencer`

## Requirements
- R1: After reset all strobes are low, the data-in bus, `rsp_rdata`, `rsp_done` and `rsp_timeout` are zero, and `cmd_ready` is high.
- R2: Opcode 0 loads `cmd_data` onto the data-in bus and runs one handshake on the address-capture strobe. A handshake raises the strobe, waits for acknowledge high, drops the strobe, then waits for acknowledge low. When acknowledge follows at once, `rsp_done` pulses 4 cycles after the accepting edge.
- R3: Opcode 1 with bit 0 clear loads `cmd_data` onto the data-in bus. It runs a handshake on the data-capture strobe, then one on the write strobe, and completes 8 cycles after acceptance when acknowledge is immediate. The data-in bus does not change from acceptance until the next accepted command.
- R4: Opcode 1 with bit 0 set raises the write strobe after the data-capture handshake. `rsp_done` pulses in the same cycle, without any wait on acknowledge (5 cycles after acceptance). The write strobe then stays high until the next command is accepted.
- R5: Opcode 2 runs a handshake on the read strobe. `rsp_rdata` takes the data-out bus as sampled by the poll that sees acknowledge high. The data-in bus keeps its previous value.
- R6: Each wait polls acknowledge first in the cycle after the strobe changes, then every `POLL_GAP` cycles, for at most `MAX_POLLS` polls. A level seen on the last allowed poll still lets the operation go on normally.
- R7: If no poll in a wait sees the expected level, `rsp_timeout` pulses and the operation stops. The strobes are left as they were until the next accepted command clears them.
- R8: Only one operation is in flight. `cmd_ready` is low from the accepting edge until the cycle after the `rsp_done` or `rsp_timeout` pulse. Each pulse lasts one cycle, and the two never coincide.
- R9: Opcode 3 is a no-op. It pulses `rsp_done` in the cycle after acceptance, clears the strobes and leaves the data-in bus unchanged.
- R10: At most one strobe is high at any time, and no clock edge changes more than one strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 2 | 0 address, 1 write, 2 read, 3 no-op |
| cmd_data | input | DW | Address or write value |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_timeout | output | 1 | One-cycle timeout pulse |
| rsp_rdata | output | DW | Data captured by the last read |
| phy_din | output | DW | Data-in bus to the PHY port |
| phy_cap_addr | output | 1 | Address-capture strobe |
| phy_cap_data | output | 1 | Data-capture strobe |
| phy_wr | output | 1 | Write-commit strobe |
| phy_rd | output | 1 | Read strobe |
| phy_ack | input | 1 | Acknowledge from the PHY |
| phy_dout | input | DW | Data-out bus from the PHY |

## Verification
The bench targets four corners: the reset-carrying write, the poll window boundary, the two timeout cases, and a read. A design that waits on acknowledge after the reset-carrying write would time out against a PHY model that ignores that strobe. A sequencer with an off-by-one poll count or gap would either finish or fail when acknowledge arrives exactly on the tenth poll, or one cycle later. A sequencer that clears strobes on timeout, or fails to time out when acknowledge is stuck high, would show the wrong strobe level and latency. A read that disturbs the data-in bus, or samples data-out at the wrong time, would return a stale or mismatched value.

// File: rtl/phy_port_sequencer.sv
module phy_port_sequencer #(
  parameter int DW        = 16,
  parameter int POLL_GAP  = 25000,
  parameter int MAX_POLLS = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] cmd_data,
  output logic          rsp_done,
  output logic          rsp_timeout,
  output logic [DW-1:0] rsp_rdata,
  output logic [DW-1:0] phy_din,
  output logic          phy_cap_addr,
  output logic          phy_cap_data,
  output logic          phy_wr,
  output logic          phy_rd,
  input  logic          phy_ack,
  input  logic [DW-1:0] phy_dout
);
  localparam int GW = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam logic [1:0] S_CA = 2'd0, S_CD = 2'd1, S_WR = 2'd2, S_RD = 2'd3;

  typedef enum logic [1:0] {IDLE, SET, WAIT} st_t;
  st_t st;

  logic [3:0]    strb;
  logic [1:0]    sel;
  logic          lvl;
  logic [GW-1:0] gap;
  logic [PW-1:0] polls;

  wire check  = (st == WAIT) && (gap == '0);
  wire hit    = check && (phy_ack == lvl);
  wire last   = (polls == PW'(MAX_POLLS - 1));
  wire nowait = (sel == S_WR) && lvl && phy_din[0];

  assign cmd_ready = (st == IDLE) && !rsp_done && !rsp_timeout;
  assign {phy_rd, phy_wr, phy_cap_data, phy_cap_addr} = strb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= IDLE;
      strb        <= '0;
      sel         <= S_CA;
      lvl         <= 1'b0;
      gap         <= '0;
      polls       <= '0;
      rsp_done    <= 1'b0;
      rsp_timeout <= 1'b0;
      rsp_rdata   <= '0;
      phy_din     <= '0;
    end else begin
      rsp_done    <= 1'b0;
      rsp_timeout <= 1'b0;
      case (st)
        IDLE: if (cmd_valid && cmd_ready) begin
          strb <= '0;
          lvl  <= 1'b1;
          case (cmd_op)
            2'd0: begin sel <= S_CA; phy_din <= cmd_data; st <= SET; end
            2'd1: begin sel <= S_CD; phy_din <= cmd_data; st <= SET; end
            2'd2: begin sel <= S_RD; st <= SET; end
            default: rsp_done <= 1'b1;
          endcase
        end
        SET: begin
          strb[sel] <= lvl;
          gap       <= '0;
          polls     <= '0;
          if (nowait) begin
            st       <= IDLE;
            rsp_done <= 1'b1;
          end else begin
            st <= WAIT;
          end
        end
        WAIT: begin
          if (gap != '0) begin
            gap <= gap - 1'b1;
          end else if (hit) begin
            if (sel == S_RD && lvl) rsp_rdata <= phy_dout;
            if (lvl) begin
              lvl <= 1'b0;
              st  <= SET;
            end else if (sel == S_CD) begin
              sel <= S_WR;
              lvl <= 1'b1;
              st  <= SET;
            end else begin
              st       <= IDLE;
              rsp_done <= 1'b1;
            end
          end else if (last) begin
            st          <= IDLE;
            rsp_timeout <= 1'b1;
          end else begin
            polls <= polls + 1'b1;
            gap   <= GW'(POLL_GAP - 1);
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({phy_rd, phy_wr, phy_cap_data, phy_cap_addr}));

  a_r10_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(strb ^ $past(strb)) <= 1));

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_done && rsp_timeout));

  a_r8_ready_back: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done || rsp_timeout) |=> cmd_ready);

  a_r3_din_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st != IDLE) |=> $stable(phy_din));

  a_r7_strobes_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_timeout |=> $stable({phy_rd, phy_wr, phy_cap_data, phy_cap_addr}));
endmodule

// File: tb/phy_port_sequencer_tb_top.sv
module phy_port_sequencer_tb_top;
  localparam int G  = 4;
  localparam int NV = 10;

  function automatic logic [57:0] mk(logic [1:0] op, logic [15:0] d, logic [15:0] rd,
                                     logic [7:0] lat, logic [15:0] cnt);
    return {op, d, rd, lat, cnt};
  endfunction

  // cnt nibbles: address-capture, data-capture, write, read rising edges
  localparam logic [57:0] VEC [NV] = '{
    mk(2'd0, 16'h0005, 16'h0000, 8'd4, 16'h1000),
    mk(2'd1, 16'h1234, 16'h0000, 8'd8, 16'h0110),
    mk(2'd0, 16'h0009, 16'h0000, 8'd4, 16'h1000),
    mk(2'd1, 16'hBEEE, 16'h0000, 8'd8, 16'h0110),
    mk(2'd0, 16'h0005, 16'h0000, 8'd4, 16'h1000),
    mk(2'd2, 16'h0000, 16'h1234, 8'd4, 16'h0001),
    mk(2'd0, 16'h0009, 16'h0000, 8'd4, 16'h1000),
    mk(2'd2, 16'h0000, 16'hBEEE, 8'd4, 16'h0001),
    mk(2'd3, 16'hFFFF, 16'h0000, 8'd0, 16'h0000),
    mk(2'd2, 16'h0000, 16'hBEEE, 8'd4, 16'h0001)
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'd0;
  logic [15:0] cmd_data = 16'h0;
  logic        rsp_done, rsp_timeout;
  logic [15:0] rsp_rdata, phy_din, phy_dout;
  logic        phy_cap_addr, phy_cap_data, phy_wr, phy_rd, phy_ack;

  phy_port_sequencer #(.DW(16), .POLL_GAP(G), .MAX_POLLS(10)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .rsp_done(rsp_done), .rsp_timeout(rsp_timeout), .rsp_rdata(rsp_rdata),
    .phy_din(phy_din), .phy_cap_addr(phy_cap_addr), .phy_cap_data(phy_cap_data),
    .phy_wr(phy_wr), .phy_rd(phy_rd), .phy_ack(phy_ack), .phy_dout(phy_dout)
  );

  int          ack_delay = 0;
  logic        mute = 1'b0;
  logic        stuck = 1'b0;
  logic [63:0] sh;
  logic [15:0] addr_q, data_q;
  logic [15:0] mem [16];
  logic [3:0]  prev;

  wire wr_eff  = phy_wr && !data_q[0];
  wire any_stb = phy_cap_addr | phy_cap_data | wr_eff | phy_rd;
  wire ack_raw = (ack_delay == 0) ? any_stb : sh[ack_delay-1];
  assign phy_ack  = stuck ? 1'b1 : (mute ? 1'b0 : ack_raw);
  assign phy_dout = mem[addr_q[3:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; addr_q <= '0; data_q <= '0; prev <= '0;
      for (int i = 0; i < 16; i++) mem[i] <= '0;
    end else begin
      sh   <= {sh[62:0], any_stb};
      prev <= {phy_rd, phy_wr, phy_cap_data, phy_cap_addr};
      if (phy_cap_addr && !prev[0]) addr_q <= phy_din;
      if (phy_cap_data && !prev[1]) data_q <= phy_din;
      if (wr_eff && !prev[2]) mem[addr_q[3:0]] <= data_q;
    end
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [15:0] d,
                        output logic got_done, output logic got_to,
                        output logic [15:0] got_rd, output int lat,
                        output logic [15:0] cnt, output logic rdy0);
    logic [3:0] pv, cur;
    int c [4];
    c = '{0, 0, 0, 0};
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_data = d; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    rdy0 = cmd_ready;
    pv = {phy_rd, phy_wr, phy_cap_data, phy_cap_addr};
    lat = 0;
    while (!(rsp_done || rsp_timeout) && lat < 4000) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
      cur = {phy_rd, phy_wr, phy_cap_data, phy_cap_addr};
      for (int k = 0; k < 4; k++) if (cur[k] && !pv[k]) c[k]++;
      pv = cur;
    end
    got_done = rsp_done;
    got_to   = rsp_timeout;
    got_rd   = rsp_rdata;
    cnt = {c[0][3:0], c[1][3:0], c[2][3:0], c[3][3:0]};
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic gd, gt, r0;
    logic [15:0] grd, gcnt, exp_din;
    int lat;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", cmd_ready, 1);
    chk("R1 strobes", {phy_rd, phy_wr, phy_cap_data, phy_cap_addr}, 0);
    chk("R1 din", phy_din, 0);
    chk("R1 pulses", {rsp_done, rsp_timeout}, 0);
    chk("R1 rdata", rsp_rdata, 0);

    exp_din = 16'h0;
    for (int v = 0; v < NV; v++) begin
      logic [1:0] op;
      op = VEC[v][57:56];
      run_op(op, VEC[v][55:40], gd, gt, grd, lat, gcnt, r0);
      if (op == 2'd0 || op == 2'd1) exp_din = VEC[v][55:40];
      chk("R8 ready low after accept", r0, 0);
      chk("R8 done not timeout", {gd, gt}, 2'b10);
      chk(op == 2'd1 ? "R3 latency" : (op == 2'd3 ? "R9 latency" : "R2 R5 latency"),
          lat, VEC[v][23:16]);
      chk("R10 strobe sequence", gcnt, VEC[v][15:0]);
      chk(op == 2'd3 ? "R9 din unchanged" : "R3 R5 din", phy_din, exp_din);
      if (op == 2'd2) chk("R5 read data", grd, VEC[v][39:24]);
      @(negedge clk);
      chk("R8 ready after done", cmd_ready, 1);
    end

    // R4: reset-carrying write, PHY ignores the write strobe
    run_op(2'd1, 16'h0001, gd, gt, grd, lat, gcnt, r0);
    chk("R4 done", {gd, gt}, 2'b10);
    chk("R4 latency", lat, 5);
    chk("R4 strobe sequence", gcnt, 16'h0110);
    chk("R4 write held at done", phy_wr, 1);
    repeat (10) @(negedge clk);
    chk("R4 write still held", phy_wr, 1);
    run_op(2'd3, 16'h0000, gd, gt, grd, lat, gcnt, r0);
    chk("R9 no-op clears write", phy_wr, 0);
    chk("R9 no-op latency", lat, 0);

    // R7: acknowledge never rises
    repeat (80) @(negedge clk);
    mute = 1'b1;
    run_op(2'd0, 16'h0003, gd, gt, grd, lat, gcnt, r0);
    chk("R7 timeout on rise", {gd, gt}, 2'b01);
    chk("R7 R6 timeout latency rise", lat, 2 + 9 * G);
    chk("R7 strobe left high", phy_cap_addr, 1);
    repeat (10) @(negedge clk);
    chk("R7 strobe still high", phy_cap_addr, 1);
    mute = 1'b0;
    run_op(2'd3, 16'h0000, gd, gt, grd, lat, gcnt, r0);
    chk("R7 next accept clears", phy_cap_addr, 0);

    // R7: acknowledge stuck high
    repeat (80) @(negedge clk);
    stuck = 1'b1;
    run_op(2'd0, 16'h0005, gd, gt, grd, lat, gcnt, r0);
    chk("R7 timeout on fall", {gd, gt}, 2'b01);
    chk("R7 R6 timeout latency fall", lat, 4 + 9 * G);
    chk("R7 strobe left low", phy_cap_addr, 0);
    stuck = 1'b0;

    // R6: acknowledge arrives on the last allowed poll, then one cycle late
    ack_delay = 8 * G + 4;
    repeat (80) @(negedge clk);
    run_op(2'd0, 16'h0007, gd, gt, grd, lat, gcnt, r0);
    chk("R6 last poll succeeds", {gd, gt}, 2'b10);
    chk("R6 last poll latency", lat, 4 + 18 * G);
    ack_delay = 8 * G + 5;
    repeat (80) @(negedge clk);
    run_op(2'd0, 16'h0007, gd, gt, grd, lat, gcnt, r0);
    chk("R6 one late times out", {gd, gt}, 2'b01);
    chk("R6 late latency", lat, 2 + 9 * G);
    ack_delay = 0;

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule